// File: doc/BRIEF.md
# Panel Power-Up and Init Sequencer

This block is the controller-side sequencer that takes a display panel from unpowered to showing pixels. On a prepare command it holds the panel in hardware reset, switches its supply rails on, waits a long settling delay, releases reset and waits a short delay. It then sends a fixed series of register writes to the panel. Each write is handed to an external SPI byte-pair master as an address and a data byte. The writes set the global reset, the regulator and common-electrode levels, eight gamma pairs, signal polarity, interface control and the input format. When the series completes, the panel is initialised and sits in standby.

Later commands enable the panel by writing the power register with normal mode and all rails on. They disable it by writing the same register with the standby bit cleared. An unprepare command cuts the supplies without any write. All configuration arrives on static input ports. If the SPI master reports an error on any write, the sequence stops at once, the supplies are dropped and an error flag stays up until the next prepare. The delays are derived from a clock-frequency parameter, so they are exact in cycles.

Top module: `pnl_boot_seq`

## Requirements
- R1: After reset, supply_en=0, panel_reset=1 (reset active), spi_req=0, and busy, ready and err are all 0.
- R2: After prepare is accepted, supply_en is 1 with panel_reset still 1 for exactly CLK_HZ/1000*LONG_MS cycles. Then panel_reset is 0 for exactly CLK_HZ/1000*SHORT_MS cycles before the first write request.
- R3: The init writes go out in this order of addresses: 0x04 (data 0x00), 0x03, 0x01, 0x02, 0x10..0x17 ascending, 0x0A, 0x0B, 0x06. Gamma register 0x10+i carries cfg_gamma[8*i+7:8*i].
- R4: The writes to 0x03 (cfg_vreg), 0x01 (cfg_vcom_amp) and 0x02 (cfg_vcom_high) are each left out when their configured code is 0xFF. The other writes keep their order.
- R5: The data written to 0x0A is {4'b0000, cfg_pol}. The data written to 0x0B is cfg_sync with bit 0 forced to 1.
- R6: The data written to 0x06 is {cfg_mode, 2'b11, ~cfg_flip_v, ~cfg_flip_h}. Bit 0 is the horizontal direction and bit 1 is the vertical direction.
- R7: While spi_req is 1 and neither spi_ack nor spi_err is seen, spi_req, spi_addr and spi_data hold. spi_addr bit 7 is always 0 (write).
- R8: After the last init write is acknowledged, ready=1 and busy=0, and no request is issued until a further command.
- R9: Enable while ready writes 0x07 with 0xEF. Disable while enabled writes 0x07 with 0xEE and returns to the ready state.
- R10: Unprepare while ready or enabled sets supply_en=0 and panel_reset=1 on the next cycle, issues no write, and clears ready.
- R11: spi_err during any write makes the next cycle show err=1, supply_en=0, panel_reset=1 and spi_req=0, with no further requests. A later prepare clears err and reruns the full sequence.
- R12: A command not valid in the current state is ignored: enable or disable while off, and disable or prepare while ready. No write is issued and the status outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_prepare | input | 1 | Pulse: power up and initialise |
| cmd_enable | input | 1 | Pulse: switch panel to normal mode |
| cmd_disable | input | 1 | Pulse: put panel in standby |
| cmd_unprepare | input | 1 | Pulse: cut supplies |
| cfg_vreg | input | 8 | Regulator level code, 0xFF keeps the panel default |
| cfg_vcom_amp | input | 8 | Common amplitude code, 0xFF keeps the panel default |
| cfg_vcom_high | input | 8 | Common high level code, 0xFF keeps the panel default |
| cfg_gamma | input | 8*N_GAMMA | Gamma bytes, byte i for register 0x10+i |
| cfg_pol | input | 4 | Polarity bits for register 0x0A |
| cfg_sync | input | 8 | Sync mode bits for register 0x0B |
| cfg_mode | input | 4 | Input format code |
| cfg_flip_h | input | 1 | Request horizontal flip |
| cfg_flip_v | input | 1 | Request vertical flip |
| supply_en | output | 1 | Supply rails enable |
| panel_reset | output | 1 | Panel hardware reset, 1 = active |
| spi_req | output | 1 | Write request to the SPI master |
| spi_addr | output | 8 | Register address, bit 7 = 0 |
| spi_data | output | 8 | Register data |
| spi_ack | input | 1 | Write finished, one cycle |
| spi_err | input | 1 | Write failed, one cycle |
| busy | output | 1 | Power-up, init or power write in progress |
| ready | output | 1 | Initialised (standby or enabled) |
| err | output | 1 | Sequence aborted by a write error |

## Verification
The assertions take for granted that the SPI master answers only a pending request, and with exactly one of spi_ack or spi_err, for a single cycle. They also take for granted that commands are single-cycle pulses. The bench's responder model keeps to this. It raises a response only after seeing spi_req at a falling edge, drops it the next falling edge, and varies its latency from zero to two cycles. The sweep walks the eight combinations of skipped optional writes, with changing polarity, sync, format and flip settings. The delays are set short through the clock-frequency parameter.

// File: rtl/pnl_boot_pkg.sv
package pnl_boot_pkg;
  typedef enum logic [3:0] {
    ST_OFF, ST_PWR, ST_RST, ST_INIT, ST_READY, ST_ENA, ST_ON, ST_DIS, ST_FAIL
  } boot_st_t;

  localparam int N_GAMMA  = 8;
  localparam int STEP_G0  = 4;
  localparam int STEP_POL = STEP_G0 + N_GAMMA;
  localparam int STEP_IFC = STEP_POL + 1;
  localparam int STEP_ENT = STEP_IFC + 1;
  localparam int N_STEPS  = STEP_ENT + 1;
  localparam int SW       = $clog2(N_STEPS);

  localparam logic [7:0] A_GRST  = 8'h04;
  localparam logic [7:0] A_VREG  = 8'h03;
  localparam logic [7:0] A_VAMP  = 8'h01;
  localparam logic [7:0] A_VHI   = 8'h02;
  localparam logic [7:0] A_GAM0  = 8'h10;
  localparam logic [7:0] A_POL   = 8'h0A;
  localparam logic [7:0] A_IFC   = 8'h0B;
  localparam logic [7:0] A_ENTRY = 8'h06;
  localparam logic [7:0] A_PWR   = 8'h07;

  localparam logic [7:0] PWR_NORMAL = 8'hEF;
  localparam logic [7:0] PWR_STBY   = 8'hEE;
  localparam logic [7:0] CODE_KEEP  = 8'hFF;
endpackage

// File: rtl/pnl_delay.sv
module pnl_delay #(
  parameter int CLK_HZ   = 125_000_000,
  parameter int LONG_MS  = 20,
  parameter int SHORT_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel_long,
  output logic expired
);
  localparam int LONG_CYC  = CLK_HZ / 1000 * LONG_MS;
  localparam int SHORT_CYC = CLK_HZ / 1000 * SHORT_MS;
  localparam int MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load)
      cnt_d = sel_long ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
    else
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pnl_step_table.sv
module pnl_step_table
  import pnl_boot_pkg::*;
(
  input  logic [SW-1:0]          step,
  input  logic [7:0]             cfg_vreg,
  input  logic [7:0]             cfg_vcom_amp,
  input  logic [7:0]             cfg_vcom_high,
  input  logic [8*N_GAMMA-1:0]   cfg_gamma,
  input  logic [3:0]             cfg_pol,
  input  logic [7:0]             cfg_sync,
  input  logic [3:0]             cfg_mode,
  input  logic                   cfg_flip_h,
  input  logic                   cfg_flip_v,
  output logic [7:0]             addr,
  output logic [7:0]             data,
  output logic                   skip,
  output logic                   last
);
  localparam int GW = (N_GAMMA > 1) ? $clog2(N_GAMMA) : 1;

  logic [SW-1:0] goff;
  logic [GW-1:0] gidx;

  assign goff = step - SW'(STEP_G0);
  assign gidx = goff[GW-1:0];
  assign last = (step == SW'(STEP_ENT));

  always_comb begin
    addr = A_GRST;
    data = 8'h00;
    skip = 1'b0;
    if (step == SW'(1)) begin
      addr = A_VREG;  data = cfg_vreg;      skip = (cfg_vreg == CODE_KEEP);
    end else if (step == SW'(2)) begin
      addr = A_VAMP;  data = cfg_vcom_amp;  skip = (cfg_vcom_amp == CODE_KEEP);
    end else if (step == SW'(3)) begin
      addr = A_VHI;   data = cfg_vcom_high; skip = (cfg_vcom_high == CODE_KEEP);
    end else if (step >= SW'(STEP_G0) && step < SW'(STEP_POL)) begin
      addr = A_GAM0 + 8'(gidx);
      data = cfg_gamma[8*gidx +: 8];
    end else if (step == SW'(STEP_POL)) begin
      addr = A_POL;   data = {4'b0000, cfg_pol};
    end else if (step == SW'(STEP_IFC)) begin
      addr = A_IFC;   data = cfg_sync | 8'h01;
    end else if (step == SW'(STEP_ENT)) begin
      addr = A_ENTRY; data = {cfg_mode, 2'b11, ~cfg_flip_v, ~cfg_flip_h};
    end
  end
endmodule

// File: rtl/pnl_boot_seq.sv
module pnl_boot_seq
  import pnl_boot_pkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int LONG_MS  = 20,
  parameter int SHORT_MS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_prepare,
  input  logic                 cmd_enable,
  input  logic                 cmd_disable,
  input  logic                 cmd_unprepare,
  input  logic [7:0]           cfg_vreg,
  input  logic [7:0]           cfg_vcom_amp,
  input  logic [7:0]           cfg_vcom_high,
  input  logic [8*N_GAMMA-1:0] cfg_gamma,
  input  logic [3:0]           cfg_pol,
  input  logic [7:0]           cfg_sync,
  input  logic [3:0]           cfg_mode,
  input  logic                 cfg_flip_h,
  input  logic                 cfg_flip_v,
  output logic                 supply_en,
  output logic                 panel_reset,
  output logic                 spi_req,
  output logic [7:0]           spi_addr,
  output logic [7:0]           spi_data,
  input  logic                 spi_ack,
  input  logic                 spi_err,
  output logic                 busy,
  output logic                 ready,
  output logic                 err
);
  boot_st_t      state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic          step_en;
  logic          tmr_load, tmr_long, tmr_exp;
  logic [7:0]    tbl_addr, tbl_data;
  logic          tbl_skip, tbl_last;

  pnl_delay #(.CLK_HZ(CLK_HZ), .LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .sel_long(tmr_long), .expired(tmr_exp)
  );

  pnl_step_table u_table (
    .step(step_q), .cfg_vreg(cfg_vreg), .cfg_vcom_amp(cfg_vcom_amp),
    .cfg_vcom_high(cfg_vcom_high), .cfg_gamma(cfg_gamma), .cfg_pol(cfg_pol),
    .cfg_sync(cfg_sync), .cfg_mode(cfg_mode), .cfg_flip_h(cfg_flip_h),
    .cfg_flip_v(cfg_flip_v), .addr(tbl_addr), .data(tbl_data),
    .skip(tbl_skip), .last(tbl_last)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    step_en  = 1'b0;
    tmr_load = 1'b0;
    tmr_long = 1'b0;
    unique case (state_q)
      ST_OFF, ST_FAIL: begin
        if (cmd_prepare) begin
          state_d  = ST_PWR;
          tmr_load = 1'b1;
          tmr_long = 1'b1;
        end
      end
      ST_PWR: begin
        if (tmr_exp) begin
          state_d  = ST_RST;
          tmr_load = 1'b1;
        end
      end
      ST_RST: begin
        if (tmr_exp) begin
          state_d = ST_INIT;
          step_d  = '0;
          step_en = 1'b1;
        end
      end
      ST_INIT: begin
        if (!tbl_skip && spi_err) begin
          state_d = ST_FAIL;
        end else if (tbl_skip || spi_ack) begin
          if (tbl_last) begin
            state_d = ST_READY;
          end else begin
            step_d  = step_q + SW'(1);
            step_en = 1'b1;
          end
        end
      end
      ST_READY: begin
        if (cmd_unprepare)   state_d = ST_OFF;
        else if (cmd_enable) state_d = ST_ENA;
      end
      ST_ON: begin
        if (cmd_unprepare)    state_d = ST_OFF;
        else if (cmd_disable) state_d = ST_DIS;
      end
      ST_ENA: begin
        if (spi_err)      state_d = ST_FAIL;
        else if (spi_ack) state_d = ST_ON;
      end
      ST_DIS: begin
        if (spi_err)      state_d = ST_FAIL;
        else if (spi_ack) state_d = ST_READY;
      end
      default: state_d = ST_OFF;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  // output decode from the state register
  always_comb begin
    supply_en   = !(state_q inside {ST_OFF, ST_FAIL});
    panel_reset = state_q inside {ST_OFF, ST_PWR, ST_FAIL};
    busy        = state_q inside {ST_PWR, ST_RST, ST_INIT, ST_ENA, ST_DIS};
    ready       = state_q inside {ST_READY, ST_ON};
    err         = (state_q == ST_FAIL);
    spi_req     = ((state_q == ST_INIT) && !tbl_skip) || (state_q inside {ST_ENA, ST_DIS});
    if (state_q == ST_INIT) begin
      spi_addr = tbl_addr;
      spi_data = tbl_data;
    end else begin
      spi_addr = A_PWR;
      spi_data = (state_q == ST_ENA) ? PWR_NORMAL : PWR_STBY;
    end
  end
endmodule

// File: rtl/pnl_boot_chk.sv
module pnl_boot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_unprepare,
  input logic       supply_en,
  input logic       panel_reset,
  input logic       spi_req,
  input logic [7:0] spi_addr,
  input logic [7:0] spi_data,
  input logic       spi_ack,
  input logic       spi_err,
  input logic       busy,
  input logic       ready,
  input logic       err
);
  // R7: a pending request holds its address and data
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_ack && !spi_err) |=> (spi_req && $stable(spi_addr) && $stable(spi_data)));

  // R7: only write addresses are issued
  a_r7_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    spi_req |-> !spi_addr[7]);

  // R11: a failed write aborts and drops the supplies
  a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && spi_err) |=> (err && !supply_en && panel_reset && !spi_req));

  // R2: supplies come up while reset is still held
  a_r2_rail_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_en) |-> panel_reset);

  // R2: no writes to an unpowered or reset panel
  a_r2_no_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req |-> (supply_en && !panel_reset)));

  // R8: a ready panel sees no traffic
  a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!spi_req && !busy));

  // R10: unprepare while ready cuts the supplies next cycle
  a_r10_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd_unprepare) |=> (!supply_en && !spi_req));

  // R1: status flags are mutually exclusive
  a_r1_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, ready, err}));
endmodule

bind pnl_boot_seq pnl_boot_chk u_chk (.*);

// File: tb/tb_pnl_boot_seq.sv
module tb_pnl_boot_seq;
  localparam int CLK_HZ    = 1000;
  localparam int LONG_EXP  = CLK_HZ / 1000 * 20;
  localparam int SHORT_EXP = CLK_HZ / 1000 * 10;

  logic clk, rst_n;
  logic cmd_prepare, cmd_enable, cmd_disable, cmd_unprepare;
  logic [7:0] cfg_vreg, cfg_vcom_amp, cfg_vcom_high, cfg_sync;
  logic [63:0] cfg_gamma;
  logic [3:0] cfg_pol, cfg_mode;
  logic cfg_flip_h, cfg_flip_v;
  logic supply_en, panel_reset, spi_req, spi_ack, spi_err, busy, ready, err;
  logic [7:0] spi_addr, spi_data;

  pnl_boot_seq #(.CLK_HZ(CLK_HZ), .LONG_MS(20), .SHORT_MS(10)) dut (.*);

  int total = 0, bad = 0;
  int lat = 0, err_at = -1, wcnt = 0, hold_bad = 0, n_log = 0;
  logic [7:0] log_a [0:63];
  logic [7:0] log_d [0:63];
  logic [7:0] e_a [0:15];
  logic [7:0] e_d [0:15];
  string      e_t [0:15];
  int ne = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // SPI byte-pair master model
  initial begin : responder
    int wn;
    logic [7:0] fa, fd;
    wn = 0; fa = 0; fd = 0;
    spi_ack = 1'b0; spi_err = 1'b0;
    forever begin
      @(negedge clk);
      if (spi_ack || spi_err) begin
        spi_ack = 1'b0; spi_err = 1'b0;
      end else if (spi_req) begin
        if (wn == 0) begin fa = spi_addr; fd = spi_data; end
        if (wn >= lat) begin
          if (spi_addr !== fa || spi_data !== fd || spi_addr[7]) hold_bad++;
          if (wcnt == err_at) spi_err = 1'b1;
          else begin
            spi_ack = 1'b1;
            if (n_log < 64) begin log_a[n_log] = spi_addr; log_d[n_log] = spi_data; end
            n_log++;
          end
          wcnt++;
          wn = 0;
        end else wn++;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic cmd(input logic [3:0] sel);
    @(negedge clk);
    {cmd_prepare, cmd_enable, cmd_disable, cmd_unprepare} = sel;
    @(negedge clk);
    {cmd_prepare, cmd_enable, cmd_disable, cmd_unprepare} = 4'b0000;
  endtask

  task automatic add_exp(input logic [7:0] a, input logic [7:0] d, input string t);
    e_a[ne] = a; e_d[ne] = d; e_t[ne] = t; ne++;
  endtask

  task automatic build_exp();
    ne = 0;
    add_exp(8'h04, 8'h00, "R3");
    if (cfg_vreg != 8'hFF)      add_exp(8'h03, cfg_vreg, "R4");
    if (cfg_vcom_amp != 8'hFF)  add_exp(8'h01, cfg_vcom_amp, "R4");
    if (cfg_vcom_high != 8'hFF) add_exp(8'h02, cfg_vcom_high, "R4");
    for (int i = 0; i < 8; i++) add_exp(8'(8'h10 + i), cfg_gamma[8*i +: 8], "R3");
    add_exp(8'h0A, {4'b0, cfg_pol}, "R5");
    add_exp(8'h0B, {cfg_sync[7:1], 1'b1}, "R5");
    add_exp(8'h06, {cfg_mode, 2'b11, !cfg_flip_v, !cfg_flip_h}, "R6");
  endtask

  task automatic wait_settle();
    for (int i = 0; i < 3000; i++) begin
      if (ready || err) break;
      @(negedge clk);
    end
  endtask

  task automatic run_prepare(input bit check_timing);
    int nh, ng;
    cmd(4'b1000);
    nh = 0; ng = 0;
    while (supply_en && panel_reset && nh < 5000) begin nh++; @(negedge clk); end
    while (supply_en && !panel_reset && !spi_req && ng < 5000) begin ng++; @(negedge clk); end
    if (check_timing) begin
      chk("R2 reset-held cycles", nh, LONG_EXP);
      chk("R2 release-to-write cycles", ng, SHORT_EXP);
    end
    wait_settle();
  endtask

  task automatic set_cfg(input int m);
    cfg_vreg      = m[0] ? 8'hFF : 8'(8'h0A + m);
    cfg_vcom_amp  = m[1] ? 8'hFF : 8'(8'h20 + m);
    cfg_vcom_high = m[2] ? 8'hFF : 8'(8'h30 + m);
    for (int i = 0; i < 8; i++) cfg_gamma[8*i +: 8] = 8'((m * 8 + i) * 37 + 5);
    cfg_pol    = 4'(m * 3 + 1);
    cfg_sync   = 8'(m * 5);
    cfg_mode   = 4'(m + 4);
    cfg_flip_h = m[0];
    cfg_flip_v = m[1];
  endtask

  task automatic check_init_log();
    build_exp();
    chk("R4 write count", n_log, ne);
    for (int i = 0; i < ne; i++) begin
      chk($sformatf("R3 addr #%0d", i), log_a[i], e_a[i]);
      chk($sformatf("%s data #%0d", e_t[i], i), log_d[i], e_d[i]);
    end
  endtask

  initial begin : main
    int base;
    rst_n = 1'b0;
    {cmd_prepare, cmd_enable, cmd_disable, cmd_unprepare} = 4'b0000;
    set_cfg(0);
    repeat (3) @(negedge clk);
    chk("R1 supply_en", supply_en, 0);
    chk("R1 panel_reset", panel_reset, 1);
    chk("R1 spi_req", spi_req, 0);
    chk("R1 status", {busy, ready, err}, 0);
    rst_n = 1'b1;

    // R12: enable and disable while off are ignored
    cmd(4'b0100);
    cmd(4'b0010);
    repeat (3) @(negedge clk);
    chk("R12 off ignores enable/disable", {supply_en, busy, ready, err}, 0);
    chk("R12 no write while off", n_log, 0);

    for (int m = 0; m < 8; m++) begin
      set_cfg(m);
      lat = m % 3;
      n_log = 0; wcnt = 0; hold_bad = 0; err_at = -1;
      run_prepare(1'b1);
      chk("R8 ready after init", {ready, busy, err}, 3'b100);
      check_init_log();
      chk("R7 request held and write-only", hold_bad, 0);
      base = n_log;
      repeat (6) @(negedge clk);
      chk("R8 no traffic when ready", n_log, base);

      // R12: disable and prepare while ready are ignored
      cmd(4'b0010);
      cmd(4'b1000);
      repeat (4) @(negedge clk);
      chk("R12 ready ignores disable/prepare", n_log, base);
      chk("R12 still ready", {ready, busy, supply_en}, 3'b101);

      cmd(4'b0100);
      repeat (lat + 4) @(negedge clk);
      chk("R9 enable write count", n_log, base + 1);
      chk("R9 enable addr", log_a[base], 8'h07);
      chk("R9 enable data", log_d[base], 8'hEF);
      chk("R9 ready when on", ready, 1);

      cmd(4'b0010);
      repeat (lat + 4) @(negedge clk);
      chk("R9 disable addr", log_a[base + 1], 8'h07);
      chk("R9 disable data", log_d[base + 1], 8'hEE);
      chk("R9 back to ready", {ready, busy}, 2'b10);

      if (m[0] == 1'b0) begin
        cmd(4'b0100);
        repeat (lat + 4) @(negedge clk);
      end
      base = n_log;
      @(negedge clk);
      cmd_unprepare = 1'b1;
      @(negedge clk);
      cmd_unprepare = 1'b0;
      chk("R10 supply off", supply_en, 0);
      chk("R10 reset active", panel_reset, 1);
      chk("R10 ready cleared", ready, 0);
      repeat (3) @(negedge clk);
      chk("R10 no write", n_log, base);
    end

    // R11: errors at several init writes
    set_cfg(3);
    lat = 1;
    for (int k = 0; k < 3; k++) begin
      n_log = 0; wcnt = 0;
      err_at = (k == 0) ? 0 : (k == 1) ? 5 : 12;
      run_prepare(1'b0);
      chk("R11 err flag", err, 1);
      chk("R11 supply dropped", supply_en, 0);
      chk("R11 reset active", panel_reset, 1);
      chk("R11 acked writes before error", n_log, err_at);
      repeat (5) @(negedge clk);
      chk("R11 no request after abort", {spi_req, 32'(n_log)}, {1'b0, 32'(err_at)});
      err_at = -1; n_log = 0; wcnt = 0;
      run_prepare(1'b1);
      chk("R11 restart clears err", {ready, err}, 2'b10);
      check_init_log();
      cmd(4'b0001);
    end

    // R11: error on the enable write
    n_log = 0; wcnt = 0; err_at = -1;
    run_prepare(1'b0);
    err_at = wcnt;
    cmd(4'b0100);
    repeat (lat + 4) @(negedge clk);
    chk("R11 enable write error", {err, supply_en, ready}, 3'b100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule